// File: doc/BRIEF.md
# Bayer Defective Pixel Corrector

This block is a streaming filter for raw colour-filter-array video. It finds impulse-noise pixels (stuck, hot or dead photosites) by comparing each pixel with the surrounding samples of its own colour, and repairs them as the video flows past. There is no list of known bad locations. Pixels enter one per clock on a valid/ready stream that carries start-of-frame and end-of-line markers. They leave on a second stream of the same kind, in raster order, with the markers regenerated.

For every pixel the block gathers a 5x5 window from four line memories. It keeps the eight samples that share the centre's colour, which sit two rows and/or two columns away, and sorts them. It then clamps the centre into a band picked by a 2-bit sensitivity level. Level 0 repairs only pixels that lie outside the whole neighbour range. Level 3 squeezes the pixel between the two middle samples, which behaves like a median filter. Samples beyond a frame edge are replaced by the same-colour sample mirrored across the centre. The line width comes from the input end-of-line marker. The frame height is read from a configuration input when start-of-frame is accepted. A bypass input passes pixels through with the same latency.

Top module: `dpc_corrector`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: With level 0 and bypass off, every output pixel equals the centre clamped into [min, max] of its eight same-colour neighbours. The neighbours are the samples at row offsets -2, 0, +2 and column offsets -2, 0, +2, excluding the centre itself.
- R3: With level k (0..3), the eight neighbours are sorted ascending into s[0..7], and the output is the centre clamped into [s[k], s[7-k]].
- R4: A neighbour column x-2 < 0 is replaced by x+2, and x+2 >= width by x-2. Rows are handled the same way with the frame height. No sample from outside the frame affects the output, including on 4x4 frames, the smallest size supported.
- R5: With `bypass` at 1, every output pixel equals the input pixel at the same position, in the same order and count as with bypass off.
- R6: While `outValid` is 1 and `outReady` is 0, the output holds its values and `inReady` is 0. No pixel is lost or repeated under any pattern of input gaps or output stalls.
- R7: Each frame yields exactly width x height output pixels in raster order. `outSof` is 1 only on the pixel (0,0), `outEol` is 1 only on the last pixel of each line, and nothing further is output after the frame.
- R8: Width and height may differ from frame to frame. The width is the count of pixels up to and including the input pixel with `inEol`. The height is `cfgHeight`, sampled with the accepted start-of-frame pixel.
- R9: Input pixels that arrive between frames without `inSof` are accepted and dropped. They do not change the next frame's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgHeight | input | ROW_W (13) | Frame height in lines, sampled at start of frame |
| cfgLevel | input | 2 | Sensitivity level k |
| bypass | input | 1 | Pass pixels unchanged with unchanged latency |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block accepts the input pixel |
| inPix | input | PIX_W (12) | Input raw sample |
| inSof | input | 1 | Input pixel is the first of a frame |
| inEol | input | 1 | Input pixel is the last of its line |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Sink accepts the output pixel |
| outPix | output | PIX_W (12) | Corrected sample |
| outSof | output | 1 | Output pixel is the first of a frame |
| outEol | output | 1 | Output pixel is the last of its line |

## Verification
The bench goes after the frame edges, where a wrong mirror would pull in stale samples from the previous line or frame. It also targets the two flush lines and two flush columns that finish a frame, where a design that counted them wrongly would emit too few pixels, extra pixels or misplaced markers. Every sensitivity level is swept over images salted with full-scale and zero spikes, so an off-by-one in the chosen sort rank shows up as a wrong clamp value. Output stalls combined with input gaps show whether a design drops or repeats pixels when its single advance enable is mis-gated. Junk pixels sent before a frame show whether a design starts a frame without a start marker.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic       adv;    // whole pipeline moves this cycle
    logic       shift;  // a scan slot enters the window
    logic       write;  // the slot carries a real pixel: store it
    logic [1:0] line;   // line memory of the current scan row
    logic       mirL;   // window slot: left neighbour mirrored
    logic       mirR;   // right neighbour mirrored
    logic       mirT;   // upper neighbour mirrored
    logic       mirB;   // lower neighbour mirrored
  } dpcStrobesT;
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] cfgHeight,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEol,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             outSof,
  output logic             outEol,
  output logic [COL_W-1:0] colAddr,
  output dpcStrobesT       strobes
);
  localparam logic [COL_W:0]   X2 = (COL_W+1)'(2);
  localparam logic [COL_W:0]   X4 = (COL_W+1)'(4);
  localparam logic [ROW_W-1:0] Y2 = ROW_W'(2);
  localparam logic [ROW_W-1:0] Y4 = ROW_W'(4);

  logic             active, tail;
  logic [COL_W:0]   vx, lineW, sx;
  logic [ROW_W-1:0] vy, frmH, sy;
  logic             adv, phantom, inFire, start, slotFire, wrapRow, emitNow;
  logic             aEmit, aSof, aEol, aMirL, aMirR, aMirT, aMirB;

  always_comb begin
    adv      = !outValid || outReady;
    phantom  = active && (tail || vy >= frmH);
    inReady  = adv && !phantom;
    inFire   = inValid && inReady;
    start    = inFire && inSof;
    slotFire = start || (active && (inFire || (adv && phantom)));
    sx       = start ? '0 : vx;
    sy       = start ? '0 : vy;
    wrapRow  = phantom && (vx == lineW + 1'b1);
    emitNow  = slotFire && (sx >= X2) && (sy >= Y2);
    colAddr  = sx[COL_W-1:0];
    strobes.adv   = adv;
    strobes.shift = slotFire;
    strobes.write = slotFire && !phantom;
    strobes.line  = sy[1:0];
    strobes.mirL  = aMirL;
    strobes.mirR  = aMirR;
    strobes.mirT  = aMirT;
    strobes.mirB  = aMirB;
  end

  // Virtual raster scan: real pixels, then two flush columns per line
  // and two flush lines per frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tail   <= 1'b0;
      vx     <= '0;
      vy     <= '0;
      lineW  <= '0;
      frmH   <= '0;
    end else begin
      if (start) frmH <= cfgHeight;
      if (slotFire) begin
        active <= 1'b1;
        if (inFire && inEol) begin
          lineW <= sx + 1'b1;
          tail  <= 1'b1;
          vx    <= sx + 1'b1;
          vy    <= sy;
        end else if (wrapRow) begin
          vx   <= '0;
          tail <= 1'b0;
          if (vy == frmH + 1'b1) active <= 1'b0;
          else vy <= vy + 1'b1;
        end else begin
          vx <= sx + 1'b1;
          vy <= sy;
        end
      end
    end
  end

  // Window-stage flags and output-stage markers
  always_ff @(posedge clk) begin
    if (rst) begin
      {aEmit, aSof, aEol, aMirL, aMirR, aMirT, aMirB} <= '0;
      {outValid, outSof, outEol} <= '0;
    end else if (adv) begin
      aEmit    <= emitNow;
      aSof     <= emitNow && (sx == X2) && (sy == Y2);
      aEol     <= emitNow && (sx == lineW + 1'b1);
      aMirL    <= sx < X4;
      aMirR    <= sx >= lineW;
      aMirT    <= sy < Y4;
      aMirB    <= sy >= frmH;
      outValid <= aEmit;
      outSof   <= aSof;
      outEol   <= aEol;
    end
  end
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int PIX_W     = 12,
  parameter int MAX_WIDTH = 1024,
  parameter int COL_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] inPix,
  input  logic [COL_W-1:0] colAddr,
  input  dpcStrobesT       strobes,
  input  logic [1:0]       level,
  input  logic             bypass,
  output logic [PIX_W-1:0] outPix
);
  localparam int LINES = 4;
  localparam int TAPS  = 5;
  localparam int NB    = 8;

  typedef logic [TAPS-1:0][PIX_W-1:0] rowT;
  typedef logic [NB-1:0][PIX_W-1:0]   nbT;

  logic [PIX_W-1:0] lineMem [LINES][MAX_WIDTH];
  rowT              winTop, winMid, winBot, up, dn;
  logic [PIX_W-1:0] newTop, newMid, center, lo, hi, fixed;
  nbT               st [NB+1];

  assign newTop = lineMem[strobes.line][colAddr];
  assign newMid = lineMem[strobes.line - 2'd2][colAddr];

  always_ff @(posedge clk) begin
    if (strobes.write) lineMem[strobes.line][colAddr] <= inPix;
  end

  // Element 0 is the newest column (x+2), element 4 the oldest (x-2)
  always_ff @(posedge clk) begin
    if (rst) begin
      winTop <= '0;
      winMid <= '0;
      winBot <= '0;
    end else if (strobes.shift) begin
      winTop <= {winTop[TAPS-2:0], newTop};
      winMid <= {winMid[TAPS-2:0], newMid};
      winBot <= {winBot[TAPS-2:0], inPix};
    end
  end

  function automatic logic [PIX_W-1:0] colL(rowT r, logic m);
    return m ? r[0] : r[TAPS-1];
  endfunction

  function automatic logic [PIX_W-1:0] colR(rowT r, logic m);
    return m ? r[TAPS-1] : r[0];
  endfunction

  function automatic nbT passStep(nbT v, int odd);
    nbT r = v;
    for (int i = odd; i < NB - 1; i += 2) begin
      if (v[i] > v[i+1]) begin
        r[i]   = v[i+1];
        r[i+1] = v[i];
      end
    end
    return r;
  endfunction

  assign up     = strobes.mirT ? winBot : winTop;
  assign dn     = strobes.mirB ? winTop : winBot;
  assign center = winMid[2];
  assign st[0]  = {colL(up, strobes.mirL), up[2], colR(up, strobes.mirR),
                   colL(winMid, strobes.mirL), colR(winMid, strobes.mirR),
                   colL(dn, strobes.mirL), dn[2], colR(dn, strobes.mirR)};

  // Odd-even transposition network: NB passes sort NB values
  for (genvar p = 0; p < NB; p++) begin : g_pass
    assign st[p+1] = passStep(st[p], p % 2);
  end

  assign lo    = st[NB][level];
  assign hi    = st[NB][3'd7 - {1'b0, level}];
  assign fixed = (center < lo) ? lo : ((center > hi) ? hi : center);

  always_ff @(posedge clk) begin
    if (rst) outPix <= '0;
    else if (strobes.adv) outPix <= bypass ? center : fixed;
  end
endmodule

// File: rtl/dpc_corrector.sv
module dpc_corrector
  import dpc_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int MAX_WIDTH  = 1024,
  parameter int MAX_HEIGHT = 4096,
  localparam int COL_W     = $clog2(MAX_WIDTH),
  localparam int ROW_W     = $clog2(MAX_HEIGHT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] cfgHeight,
  input  logic [1:0]       cfgLevel,
  input  logic             bypass,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inPix,
  input  logic             inSof,
  input  logic             inEol,
  output logic             outValid,
  input  logic             outReady,
  output logic [PIX_W-1:0] outPix,
  output logic             outSof,
  output logic             outEol
);
  dpcStrobesT       strobes;
  logic [COL_W-1:0] colAddr;

  dpc_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W)) i_ctrl (
    .clk(clk), .rst(rst), .cfgHeight(cfgHeight), .inValid(inValid),
    .inSof(inSof), .inEol(inEol), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .outSof(outSof), .outEol(outEol),
    .colAddr(colAddr), .strobes(strobes)
  );

  dpc_datapath #(.PIX_W(PIX_W), .MAX_WIDTH(MAX_WIDTH), .COL_W(COL_W)) i_datapath (
    .clk(clk), .rst(rst), .inPix(inPix), .colAddr(colAddr),
    .strobes(strobes), .level(cfgLevel), .bypass(bypass), .outPix(outPix)
  );
endmodule

// File: rtl/dpc_corrector_chk.sv
module dpc_corrector_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outPix,
  input logic             outSof,
  input logic             outEol
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !outValid); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outPix) && $stable(outSof) && $stable(outEol)); // R6

  AST_NO_INTAKE_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady); // R6

  AST_SOF_NOT_EOL: assert property (@(posedge clk) disable iff (rst)
    outValid && outSof |-> !outEol); // R7
endmodule

bind dpc_corrector dpc_corrector_chk #(.PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outPix(outPix), .outSof(outSof), .outEol(outEol)
);

// File: tb/test_dpc_corrector.sv
module test_dpc_corrector;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 12;
  localparam int RW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] cfgHeight = '0;
  logic [1:0]    cfgLevel = '0;
  logic          bypass = 1'b0;
  logic          inValid = 1'b0, inSof = 1'b0, inEol = 1'b0;
  logic [PW-1:0] inPix = '0;
  logic          inReady, outValid, outSof, outEol;
  logic          outReady = 1'b1;
  logic [PW-1:0] outPix;

  int checks = 0;
  int errors = 0;
  int img [16][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpc_corrector i_dpc_corrector (
    .clk(clk), .rst(rst), .cfgHeight(cfgHeight), .cfgLevel(cfgLevel),
    .bypass(bypass), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .inSof(inSof), .inEol(inEol), .outValid(outValid), .outReady(outReady),
    .outPix(outPix), .outSof(outSof), .outEol(outEol)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic fillImg(int w, int h, int seed);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        img[y][x] = ((x * 37 + y * 91 + seed * 13) % 2048) + 1000;
        if ((x * 3 + y * 5 + seed) % 7 == 0) img[y][x] = ((x + y) % 2 != 0) ? 4095 : 0;
      end
  endtask

  // Model of the rule: mirrored same-colour neighbours, sort, clamp
  function automatic int expectPix(int x, int y, int w, int h, int k, bit byp);
    int xs[3], ys[3], nb[8], n, t, c;
    xs[0] = (x < 2) ? x + 2 : x - 2; xs[1] = x; xs[2] = (x + 2 >= w) ? x - 2 : x + 2;
    ys[0] = (y < 2) ? y + 2 : y - 2; ys[1] = y; ys[2] = (y + 2 >= h) ? y - 2 : y + 2;
    c = img[y][x];
    if (byp) return c;
    n = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        if (!(i == 1 && j == 1)) begin nb[n] = img[ys[i]][xs[j]]; n++; end
    for (int i = 1; i < 8; i++)
      for (int j = i; j > 0 && nb[j-1] > nb[j]; j--) begin
        t = nb[j]; nb[j] = nb[j-1]; nb[j-1] = t;
      end
    if (c < nb[k]) return nb[k];
    if (c > nb[7-k]) return nb[7-k];
    return c;
  endfunction

  task automatic sendPix(int v, bit s, bit e);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      inValid = 1'b1; inPix = PW'(v); inSof = s; inEol = e;
      #1 acc = inReady;
      @(posedge clk);
    end
  endtask

  task automatic sendFrame(int w, int h, bit gaps, int junk);
    for (int j = 0; j < junk; j++) sendPix(4095 - j, 1'b0, (j % 2) == 1);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        if (gaps && ((x + y) % 3 == 0)) begin
          @(negedge clk); inValid = 1'b0; @(posedge clk);
        end
        sendPix(img[y][x], (x == 0 && y == 0), (x == w - 1));
      end
    @(negedge clk); inValid = 1'b0; inSof = 1'b0; inEol = 1'b0;
  endtask

  task automatic collect(int w, int h, int k, bit byp, bit bp, string tag);
    int got = 0;
    int cyc = 0;
    int x, y, act, exp;
    while (got < w * h) begin
      @(negedge clk);
      outReady = bp ? ((cyc % 5) != 1 && (cyc % 5) != 3) : 1'b1;
      cyc++;
      #1;
      if (outValid && outReady) begin
        x = got % w; y = got / w;
        act = int'(outPix) * 4 + int'(outSof) * 2 + int'(outEol);
        exp = expectPix(x, y, w, h, k, byp) * 4 + ((x == 0 && y == 0) ? 2 : 0) + ((x == w - 1) ? 1 : 0);
        check(act == exp, tag, $sformatf("pixel*4+sof*2+eol at (%0d,%0d)", x, y), act, exp);
        got++;
      end
    end
  endtask

  task automatic runFrame(int w, int h, int k, bit byp, bit bp, int junk, int seed, string tag);
    int extra = 0;
    fillImg(w, h, seed);
    @(negedge clk);
    cfgHeight = RW'(h); cfgLevel = 2'(k); bypass = byp;
    fork
      sendFrame(w, h, bp, junk);
      collect(w, h, k, byp, bp, tag);
    join
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); outReady = 1'b1; #1;
      if (outValid) extra++;
    end
    // R7: nothing beyond width x height
    check(extra == 0, "R7", "extra output pixels after frame", extra, 0);
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R6 watchdog expired: actual %0d checks expected completion", checks);
    finishSim();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    runFrame(8, 6, 0, 1'b0, 1'b0, 0, 1, "R2");
    runFrame(8, 6, 1, 1'b0, 1'b0, 0, 2, "R3");
    runFrame(8, 6, 2, 1'b0, 1'b0, 0, 3, "R3");
    runFrame(8, 6, 3, 1'b0, 1'b0, 0, 4, "R3");
    runFrame(8, 6, 3, 1'b1, 1'b0, 0, 5, "R5");
    runFrame(4, 4, 0, 1'b0, 1'b0, 0, 6, "R4");
    runFrame(5, 4, 3, 1'b0, 1'b0, 0, 10, "R4");
    runFrame(7, 5, 2, 1'b0, 1'b1, 0, 7, "R6");
    runFrame(12, 9, 1, 1'b0, 1'b0, 0, 8, "R8");
    runFrame(6, 4, 3, 1'b0, 1'b1, 3, 9, "R9");
    finishSim();
  end
endmodule